// File: doc/BRIEF.md
# Compressed Block Placement Allocator

This block decides where a compressed 16-byte virtual block is stored in a physical data memory of 52 lines of 40 bits. Each of the 32 virtual blocks owns a fixed home line (line number equal to the block number). The home line gives up 6 bits to an overflow link, a 5-bit pointer plus a valid flag, which leaves 34 bits for compressed data. A block whose compressed length is larger than that spills into one extra line taken from a shared pool of 20 overflow lines (lines 32 to 51). The link to that line is kept with the block's home line.

The compressor sits outside. It presents a block number, a compressed length in bits and an operation (store or look up). One cycle later the allocator answers with the home line, the overflow line if there is one, and error flags. A 52-bit occupancy map, one bit per physical line, is always visible on a port so that software can read it.

Top module: `blk_place_alloc`

## Requirements
- R1: After reset every occupancy bit is 0, no block holds an overflow line and `rsp_valid` is 0.
- R2: Each request (`req_valid`=1) produces exactly one response with `rsp_valid`=1 in the following cycle, and `rsp_home` equals the requested block number. A cycle without a request gives `rsp_valid`=0 in the next cycle.
- R3: A store (`req_op`=1) that is not rejected for size sets occupancy bit `free_map[blk]` to 1. In the map, bit i stands for physical line i and 1 means in use.
- R4: A store longer than 34 bits to a block with no overflow line claims the lowest-numbered unused line among 32..51 and sets its map bit. The response gives `rsp_ovf_hit`=1 and `rsp_ovf_line` equal to 32 plus the stored 5-bit pointer.
- R5: A store longer than 34 bits to a block that already holds an overflow line reuses that line. The response reports it and the map is unchanged apart from R3.
- R6: A store of at most 34 bits releases any overflow line the block holds: its map bit goes to 0 and the response has `rsp_ovf_hit`=0.
- R7: When R4 applies but all 20 overflow lines are in use, `rsp_err_full`=1, `rsp_ovf_hit`=0, the map stays unchanged apart from R3, and the block is left without an overflow line.
- R8: A store longer than 74 bits (34 + 40) sets `rsp_err_big`=1 and changes neither the map nor the block's overflow link.
- R9: A look-up (`req_op`=0) returns the block's current overflow line (or `rsp_ovf_hit`=0 if it has none) and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 1 | 1 = store, 0 = look-up |
| req_blk | input | 5 | Virtual block number |
| req_len | input | 8 | Compressed length in bits |
| rsp_valid | output | 1 | Response strobe |
| rsp_home | output | 6 | Home line of the block |
| rsp_ovf_hit | output | 1 | Block has an overflow line |
| rsp_ovf_line | output | 6 | Overflow line number (32..51) |
| rsp_err_full | output | 1 | No overflow line was free |
| rsp_err_big | output | 1 | Length exceeds home plus one overflow line |
| free_map | output | 52 | Occupancy map, one bit per line |

## Verification
Every response field and the occupancy map take their new values at the first rising edge after the request is presented, with a single register stage in between. The bench therefore applies a request at a falling edge, waits one rising edge, and compares all outputs at the next falling edge against a model updated from its state before the request. A cycle with no request is checked the same way for a low `rsp_valid`. The corner cases include reclaiming a released line before higher ones, reuse of a held line, exhausting the pool, and size rejection. These are driven directly before a long seeded random run.

// File: rtl/blk_place_pkg.sv
package blk_place_pkg;
    typedef enum logic {
        OP_LOOKUP = 1'b0,
        OP_STORE  = 1'b1
    } place_op_e;
endpackage

// File: rtl/blk_len_class.sv
module blk_len_class #(
    parameter int LEN_W  = 8,
    parameter int HOME_CAP = 34,
    parameter int LINE_W = 40
) (
    input  logic [LEN_W-1:0] len,
    output logic             need_ovf,
    output logic             too_big
);
    always_comb begin
        need_ovf = int'(len) > HOME_CAP;
        too_big  = int'(len) > (HOME_CAP + LINE_W);
    end
endmodule

// File: rtl/blk_dyn_pick.sv
module blk_dyn_pick #(
    parameter int N_DYN = 20,
    parameter int PTR_W = 5
) (
    input  logic [N_DYN-1:0] used,
    output logic             found,
    output logic [PTR_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_DYN - 1; i >= 0; i--) begin
            if (!used[i]) begin
                found = 1'b1;
                idx   = PTR_W'(i);
            end
        end
    end

    logic [N_DYN-1:0] below_mask;
    always_comb begin
        below_mask = (N_DYN'(1) << idx) - N_DYN'(1);
        if (found) begin
            AST_PICK_LOWEST: assert (!used[idx] && ((used & below_mask) == below_mask)); // R4
        end
    end
endmodule

// File: rtl/blk_place_alloc.sv
module blk_place_alloc #(
    parameter int N_BLK  = 32,
    parameter int N_DYN  = 20,
    parameter int LINE_W = 40,
    parameter int LEN_W  = 8,
    localparam int N_LINE   = N_BLK + N_DYN,
    localparam int BLK_W    = $clog2(N_BLK),
    localparam int PTR_W    = $clog2(N_DYN),
    localparam int LINE_IW  = $clog2(N_LINE),
    localparam int HOME_CAP = LINE_W - PTR_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_op,
    input  logic [BLK_W-1:0]   req_blk,
    input  logic [LEN_W-1:0]   req_len,
    output logic               rsp_valid,
    output logic [LINE_IW-1:0] rsp_home,
    output logic               rsp_ovf_hit,
    output logic [LINE_IW-1:0] rsp_ovf_line,
    output logic               rsp_err_full,
    output logic               rsp_err_big,
    output logic [N_LINE-1:0]  free_map
);
    import blk_place_pkg::*;

    typedef struct packed {
        logic [N_LINE-1:0]            used;
        logic [N_BLK-1:0]             link_vld;
        logic [N_BLK-1:0][PTR_W-1:0]  link_ptr;
        logic                         rsp_valid;
        logic [LINE_IW-1:0]           rsp_home;
        logic                         rsp_ovf_hit;
        logic [LINE_IW-1:0]           rsp_ovf_line;
        logic                         rsp_err_full;
        logic                         rsp_err_big;
    } state_t;

    state_t st_d, st_q;

    logic             need_ovf, too_big;
    logic             pick_found;
    logic [PTR_W-1:0] pick_idx;

    blk_len_class #(
        .LEN_W(LEN_W), .HOME_CAP(HOME_CAP), .LINE_W(LINE_W)
    ) u_len (
        .len(req_len), .need_ovf(need_ovf), .too_big(too_big)
    );

    blk_dyn_pick #(
        .N_DYN(N_DYN), .PTR_W(PTR_W)
    ) u_pick (
        .used(st_q.used[N_LINE-1:N_BLK]), .found(pick_found), .idx(pick_idx)
    );

    logic             cur_vld;
    logic [PTR_W-1:0] cur_ptr;

    always_comb begin
        st_d              = st_q;
        cur_vld           = st_q.link_vld[req_blk];
        cur_ptr           = st_q.link_ptr[req_blk];
        st_d.rsp_valid    = req_valid;
        st_d.rsp_home     = LINE_IW'(req_blk);
        st_d.rsp_ovf_hit  = 1'b0;
        st_d.rsp_ovf_line = '0;
        st_d.rsp_err_full = 1'b0;
        st_d.rsp_err_big  = 1'b0;
        if (req_valid) begin
            if (place_op_e'(req_op) == OP_LOOKUP) begin
                st_d.rsp_ovf_hit  = cur_vld;
                st_d.rsp_ovf_line = cur_vld ? LINE_IW'(N_BLK) + LINE_IW'(cur_ptr) : '0;
            end else if (too_big) begin
                st_d.rsp_err_big = 1'b1;
            end else begin
                st_d.used[req_blk] = 1'b1;
                if (need_ovf) begin
                    if (cur_vld) begin
                        st_d.rsp_ovf_hit  = 1'b1;
                        st_d.rsp_ovf_line = LINE_IW'(N_BLK) + LINE_IW'(cur_ptr);
                    end else if (pick_found) begin
                        st_d.used[LINE_IW'(N_BLK) + LINE_IW'(pick_idx)] = 1'b1;
                        st_d.link_vld[req_blk] = 1'b1;
                        st_d.link_ptr[req_blk] = pick_idx;
                        st_d.rsp_ovf_hit  = 1'b1;
                        st_d.rsp_ovf_line = LINE_IW'(N_BLK) + LINE_IW'(pick_idx);
                    end else begin
                        st_d.rsp_err_full = 1'b1;
                    end
                end else if (cur_vld) begin
                    st_d.used[LINE_IW'(N_BLK) + LINE_IW'(cur_ptr)] = 1'b0;
                    st_d.link_vld[req_blk] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid    = st_q.rsp_valid;
    assign rsp_home     = st_q.rsp_home;
    assign rsp_ovf_hit  = st_q.rsp_ovf_hit;
    assign rsp_ovf_line = st_q.rsp_ovf_line;
    assign rsp_err_full = st_q.rsp_err_full;
    assign rsp_err_big  = st_q.rsp_err_big;
    assign free_map     = st_q.used;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_valid && rsp_home == LINE_IW'($past(req_blk)))); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_FULL_KEEPS_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_full |-> $stable(free_map[N_LINE-1:N_BLK])); // R7
    AST_BIG_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_big |-> $stable(free_map)); // R8
    AST_OVF_IN_POOL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ovf_hit |-> (rsp_ovf_line >= LINE_IW'(N_BLK) && rsp_ovf_line < LINE_IW'(N_LINE)
                         && free_map[rsp_ovf_line])); // R4
    AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(free_map[N_LINE-1:N_BLK]) <= $past($countones(free_map[N_LINE-1:N_BLK])) + 1); // R4
    AST_LOOKUP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op) |=> $stable(free_map)); // R9
endmodule

// File: tb/blk_place_alloc_bench.sv
module blk_place_alloc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [4:0]  req_blk = '0;
    logic [7:0]  req_len = '0;
    logic        rsp_valid;
    logic [5:0]  rsp_home;
    logic        rsp_ovf_hit;
    logic [5:0]  rsp_ovf_line;
    logic        rsp_err_full;
    logic        rsp_err_big;
    logic [51:0] free_map;

    int n_chk = 0;
    int n_err = 0;

    logic [51:0] m_used = '0;
    logic [31:0] m_vld = '0;
    int          m_ptr [32];

    always #5 clk = ~clk;

    blk_place_alloc u_blk_place_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_blk(req_blk), .req_len(req_len), .rsp_valid(rsp_valid),
        .rsp_home(rsp_home), .rsp_ovf_hit(rsp_ovf_hit), .rsp_ovf_line(rsp_ovf_line),
        .rsp_err_full(rsp_err_full), .rsp_err_big(rsp_err_big), .free_map(free_map)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int lowest_free();
        for (int i = 32; i < 52; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    task automatic do_req(bit wr, int blk, int len, string tag);
        bit e_hit, e_full, e_big;
        int e_line;
        req_valid = 1'b1; req_op = wr; req_blk = 5'(blk); req_len = 8'(len);
        @(posedge clk);
        @(negedge clk);
        e_hit = 0; e_full = 0; e_big = 0; e_line = 0;
        if (!wr) begin
            e_hit = m_vld[blk]; e_line = 32 + m_ptr[blk];
        end else if (len > 74) begin
            e_big = 1;
        end else begin
            m_used[blk] = 1'b1;
            if (len > 34) begin
                if (m_vld[blk]) begin
                    e_hit = 1; e_line = 32 + m_ptr[blk];
                end else if (lowest_free() >= 0) begin
                    e_line = lowest_free(); e_hit = 1;
                    m_used[e_line] = 1'b1; m_vld[blk] = 1'b1; m_ptr[blk] = e_line - 32;
                end else begin
                    e_full = 1;
                end
            end else if (m_vld[blk]) begin
                m_used[32 + m_ptr[blk]] = 1'b0; m_vld[blk] = 1'b0;
            end
        end
        chk(tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(tag, "rsp_home", 64'(rsp_home), 64'(blk));
        chk(tag, "rsp_ovf_hit", 64'(rsp_ovf_hit), 64'(e_hit));
        if (e_hit) chk(tag, "rsp_ovf_line", 64'(rsp_ovf_line), 64'(e_line));
        chk(tag, "rsp_err_full", 64'(rsp_err_full), 64'(e_full));
        chk(tag, "rsp_err_big", 64'(rsp_err_big), 64'(e_big));
        chk(tag, "free_map", 64'(free_map), 64'(m_used));
        req_valid = 1'b0;
    endtask

    task automatic idle_chk();
        @(posedge clk);
        @(negedge clk);
        chk("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R2", "idle free_map", 64'(free_map), 64'(m_used));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd2741));
        for (int i = 0; i < 32; i++) m_ptr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset free_map", 64'(free_map), 64'd0);
        chk("R1", "reset rsp_valid", 64'(rsp_valid), 64'd0);
        do_req(0, 5, 0, "R1");            // nothing held after reset
        do_req(1, 0, 10, "R3");           // small store, home only
        do_req(1, 1, 50, "R4");           // overflow to line 32
        do_req(1, 2, 60, "R4");           // overflow to line 33
        do_req(1, 2, 35, "R5");           // reuse held line 33
        do_req(1, 1, 34, "R6");           // exactly at home capacity: release 32
        idle_chk();
        do_req(1, 3, 74, "R4");           // lowest free again is 32
        do_req(0, 3, 0, "R9");
        do_req(1, 3, 75, "R8");           // too big, link kept
        do_req(0, 3, 0, "R8");
        for (int b = 4; b < 22; b++) do_req(1, b, 40, "R4");
        do_req(1, 30, 70, "R7");          // pool exhausted
        do_req(0, 30, 0, "R7");
        do_req(1, 3, 1, "R6");
        do_req(1, 30, 70, "R4");          // freed line reused
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(9, 0) == 0) idle_chk();
            else do_req(1'($urandom_range(1, 0)), int'($urandom_range(31, 0)),
                        int'($urandom_range(90, 0)), "R2");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule